// File: doc/BRIEF.md
# Transmit Equalizer Coefficient Update Responder

This block sits in one lane of a backplane link-training receiver path and acts on equalizer requests sent by the link partner. It holds the local transmitter's three tap settings: pre-cursor, main and post-cursor. Every clock it reads a 16-bit coefficient-update word. It applies per-tap increment, decrement or hold requests, or a whole-set initialize or preset command. It then answers with a 16-bit status word that tells the partner how each tap responded.

Each tap moves by at most one step per request. A tap that would cross its limit stays where it is, and its status reports the saturation. Software can replace four of the limits (main maximum, main minimum, post maximum and pre maximum) with its own values through a value input and an enable input for each. The local receiver-ready flag is carried in the top bit of the status word.

Top module: `txeq_coef_responder`

## Requirements
- R1: While reset is low and in the first cycle after it, the taps hold their initial parameter values and all three status fields read 00 (not updated).
- R2: A request of 01 (increment) or 10 (decrement) on a tap whose status is 00 moves that tap by exactly one. The tap's status field becomes 10 (updated) on the clock edge that samples the request.
- R3: While a tap's request stays non-hold, its status keeps its value and the tap does not move again. When the request returns to hold, the status goes back to 00 on the next edge.
- R4: An increment on a tap at or above its maximum leaves the tap unchanged and reports 11 (maximum). A decrement on a tap at or below its minimum leaves the tap unchanged and reports 01 (minimum). The pre and post minimums are 0.
- R5: The reserved request code 11 behaves exactly like hold.
- R6: Update-word bit 12 (initialize) loads the initial values into all three taps and sets every status field to 10. Any per-tap request in the same word is ignored.
- R7: Update-word bit 13 (preset) loads the main tap with its preset value and sets pre and post to 0, with every status field 10. When bits 12 and 13 are both set, the preset wins.
- R8: When a limit's override enable is high, its override value replaces the default limit for that comparison. When the enable is low, the default limit applies.
- R9: Status bit 15 equals the receiver-ready input in the same cycle. Status bits 14 to 6 read 0.
- R10: In both the update word and the status word, bits [5:4] belong to the post-cursor tap, bits [3:2] to the main tap and bits [1:0] to the pre-cursor tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_word | input | 16 | Received coefficient-update word |
| rx_ready | input | 1 | Local receiver-ready flag |
| main_max_ovr | input | MAIN_W | Override value for the main maximum |
| main_max_ovr_en | input | 1 | Enable for the main-maximum override |
| main_min_ovr | input | MAIN_W | Override value for the main minimum |
| main_min_ovr_en | input | 1 | Enable for the main-minimum override |
| post_max_ovr | input | POST_W | Override value for the post maximum |
| post_max_ovr_en | input | 1 | Enable for the post-maximum override |
| pre_max_ovr | input | PRE_W | Override value for the pre maximum |
| pre_max_ovr_en | input | 1 | Enable for the pre-maximum override |
| stat_word | output | 16 | Status word returned to the partner |
| pre_tap | output | PRE_W | Pre-cursor tap setting |
| main_tap | output | MAIN_W | Main tap setting |
| post_tap | output | POST_W | Post-cursor tap setting |

## Verification
The assertions assume that an enabled main-maximum override lies above the initial main value. They also assume that an enabled main-minimum override lies strictly between the default minimum and the initial main value. The stimulus changes these overrides only on the inactive clock edge and only to values that meet both conditions. The step-size property assumes the taps are driven only by this block's own commands. The stimulus follows every request with hold, or deliberately holds a request for several cycles, so that the partner's handshake is modelled.

// File: rtl/txeq_coef_responder.sv
module txeq_coef_responder #(
  parameter int MAIN_W       = 5,
  parameter int POST_W       = 6,
  parameter int PRE_W        = 5,
  parameter int MAIN_INIT    = 20,
  parameter int POST_INIT    = 8,
  parameter int PRE_INIT     = 4,
  parameter int MAIN_PRESET  = 28,
  parameter int MAIN_MAX_DEF = 31,
  parameter int MAIN_MIN_DEF = 4,
  parameter int POST_MAX_DEF = 40,
  parameter int PRE_MAX_DEF  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       upd_word,
  input  logic              rx_ready,
  input  logic [MAIN_W-1:0] main_max_ovr,
  input  logic              main_max_ovr_en,
  input  logic [MAIN_W-1:0] main_min_ovr,
  input  logic              main_min_ovr_en,
  input  logic [POST_W-1:0] post_max_ovr,
  input  logic              post_max_ovr_en,
  input  logic [PRE_W-1:0]  pre_max_ovr,
  input  logic              pre_max_ovr_en,
  output logic [15:0]       stat_word,
  output logic [PRE_W-1:0]  pre_tap,
  output logic [MAIN_W-1:0] main_tap,
  output logic [POST_W-1:0] post_tap
);
  localparam int TW = (MAIN_W > POST_W) ? ((MAIN_W > PRE_W) ? MAIN_W : PRE_W)
                                        : ((POST_W > PRE_W) ? POST_W : PRE_W);
  localparam logic [1:0] ST_NONE = 2'b00, ST_MIN = 2'b01, ST_UPD = 2'b10, ST_MAX = 2'b11;

  logic [1:0] st_pre, st_main, st_post;

  wire do_preset = upd_word[13];
  wire do_init   = upd_word[12] & ~upd_word[13];
  wire do_load   = upd_word[12] | upd_word[13];

  wire [TW-1:0] lim_main_max = TW'(main_max_ovr_en ? main_max_ovr : MAIN_W'(MAIN_MAX_DEF));
  wire [TW-1:0] lim_main_min = TW'(main_min_ovr_en ? main_min_ovr : MAIN_W'(MAIN_MIN_DEF));
  wire [TW-1:0] lim_post_max = TW'(post_max_ovr_en ? post_max_ovr : POST_W'(POST_MAX_DEF));
  wire [TW-1:0] lim_pre_max  = TW'(pre_max_ovr_en  ? pre_max_ovr  : PRE_W'(PRE_MAX_DEF));

  function automatic logic [TW+1:0] tap_step(input logic [TW-1:0] tap, input logic [1:0] st,
                                             input logic [1:0] rq, input logic [TW-1:0] mx,
                                             input logic [TW-1:0] mn);
    logic [TW-1:0] t;
    logic [1:0]    s;
    t = tap;
    s = st;
    if (st != ST_NONE) begin
      if (rq == 2'b00 || rq == 2'b11) s = ST_NONE;
    end else if (rq == 2'b01) begin
      if (tap >= mx) s = ST_MAX;
      else begin t = tap + 1'b1; s = ST_UPD; end
    end else if (rq == 2'b10) begin
      if (tap <= mn) s = ST_MIN;
      else begin t = tap - 1'b1; s = ST_UPD; end
    end
    return {s, t};
  endfunction

  wire [TW+1:0] nx_pre  = tap_step(TW'(pre_tap),  st_pre,  upd_word[1:0], lim_pre_max,  '0);
  wire [TW+1:0] nx_main = tap_step(TW'(main_tap), st_main, upd_word[3:2], lim_main_max, lim_main_min);
  wire [TW+1:0] nx_post = tap_step(TW'(post_tap), st_post, upd_word[5:4], lim_post_max, '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_tap  <= PRE_W'(PRE_INIT);
      main_tap <= MAIN_W'(MAIN_INIT);
      post_tap <= POST_W'(POST_INIT);
      {st_pre, st_main, st_post} <= '0;
    end else if (do_preset) begin
      pre_tap  <= '0;
      main_tap <= MAIN_W'(MAIN_PRESET);
      post_tap <= '0;
      {st_pre, st_main, st_post} <= {ST_UPD, ST_UPD, ST_UPD};
    end else if (do_init) begin
      pre_tap  <= PRE_W'(PRE_INIT);
      main_tap <= MAIN_W'(MAIN_INIT);
      post_tap <= POST_W'(POST_INIT);
      {st_pre, st_main, st_post} <= {ST_UPD, ST_UPD, ST_UPD};
    end else begin
      pre_tap  <= nx_pre[PRE_W-1:0];
      main_tap <= nx_main[MAIN_W-1:0];
      post_tap <= nx_post[POST_W-1:0];
      st_pre   <= nx_pre[TW+1:TW];
      st_main  <= nx_main[TW+1:TW];
      st_post  <= nx_post[TW+1:TW];
    end
  end

  assign stat_word = {rx_ready, 9'b0, st_post, st_main, st_pre};

  assert_main_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(do_load) |-> (int'(main_tap) - int'($past(main_tap)) <= 1 &&
                         int'($past(main_tap)) - int'(main_tap) <= 1));
  assert_hold_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_load && (upd_word[3:2] == 2'b00 || upd_word[3:2] == 2'b11)) |=>
      (stat_word[3:2] == ST_NONE && $stable(main_tap)));
  assert_sat_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[5:4] == ST_MAX || stat_word[5:4] == ST_MIN) |-> $stable(post_tap));
  assert_init_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_init |=> (main_tap == MAIN_W'(MAIN_INIT) && pre_tap == PRE_W'(PRE_INIT) &&
                 post_tap == POST_W'(POST_INIT)));
  assert_preset_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_word[13] |=> (pre_tap == '0 && post_tap == '0 && stat_word[5:0] == 6'b101010));
  assert_ovr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_max_ovr_en || int'(main_max_ovr) > MAIN_INIT) &&
    (!main_min_ovr_en || (int'(main_min_ovr) < MAIN_INIT && int'(main_min_ovr) > MAIN_MIN_DEF)));
endmodule

// File: tb/sim_txeq_coef_responder.sv
`timescale 1ns/1ps
module sim_txeq_coef_responder;
  localparam int MAIN_INIT = 20, POST_INIT = 8, PRE_INIT = 4, MAIN_PRESET = 28;
  localparam int MAIN_MAX_DEF = 31, MAIN_MIN_DEF = 4, POST_MAX_DEF = 40, PRE_MAX_DEF = 20;

  logic clk = 0, rst_n = 0, rx_ready = 0;
  logic [15:0] upd_word = '0;
  logic [4:0] main_max_ovr = '0, main_min_ovr = '0, pre_max_ovr = '0;
  logic [5:0] post_max_ovr = '0;
  logic main_max_ovr_en = 0, main_min_ovr_en = 0, post_max_ovr_en = 0, pre_max_ovr_en = 0;
  logic [15:0] stat_word;
  logic [4:0] pre_tap, main_tap;
  logic [5:0] post_tap;

  txeq_coef_responder u0 (.clk, .rst_n, .upd_word, .rx_ready, .main_max_ovr, .main_max_ovr_en,
    .main_min_ovr, .main_min_ovr_en, .post_max_ovr, .post_max_ovr_en, .pre_max_ovr,
    .pre_max_ovr_en, .stat_word, .pre_tap, .main_tap, .post_tap);

  always #2 clk = ~clk;

  int checks = 0, bad = 0;
  int q_pre[$], q_main[$], q_post[$], q_st[$];
  string q_tag[$];
  int m_pre = PRE_INIT, m_main = MAIN_INIT, m_post = POST_INIT;
  logic [1:0] s_pre = 0, s_main = 0, s_post = 0;

  task automatic model_tap(inout int tap, inout logic [1:0] st, input logic [1:0] rq,
                           input int mx, input int mn);
    if (st != 2'b00) begin
      if (rq == 2'b00 || rq == 2'b11) st = 2'b00;
    end else if (rq == 2'b01) begin
      if (tap >= mx) st = 2'b11; else begin tap++; st = 2'b10; end
    end else if (rq == 2'b10) begin
      if (tap <= mn) st = 2'b01; else begin tap--; st = 2'b10; end
    end
  endtask

  task automatic step(input logic [15:0] w, input string tag);
    @(negedge clk);
    upd_word = w;
    if (w[13]) begin
      m_main = MAIN_PRESET; m_pre = 0; m_post = 0; {s_pre, s_main, s_post} = 6'b101010;
    end else if (w[12]) begin
      m_main = MAIN_INIT; m_pre = PRE_INIT; m_post = POST_INIT; {s_pre, s_main, s_post} = 6'b101010;
    end else begin
      model_tap(m_pre, s_pre, w[1:0], pre_max_ovr_en ? int'(pre_max_ovr) : PRE_MAX_DEF, 0);
      model_tap(m_main, s_main, w[3:2], main_max_ovr_en ? int'(main_max_ovr) : MAIN_MAX_DEF,
                main_min_ovr_en ? int'(main_min_ovr) : MAIN_MIN_DEF);
      model_tap(m_post, s_post, w[5:4], post_max_ovr_en ? int'(post_max_ovr) : POST_MAX_DEF, 0);
    end
    q_pre.push_back(m_pre); q_main.push_back(m_main); q_post.push_back(m_post);
    q_st.push_back(int'({rx_ready, 9'b0, s_post, s_main, s_pre}));
    q_tag.push_back(tag);
  endtask

  task automatic pulse(input logic [15:0] w, input string tag);
    step(w, tag);
    step(16'h0000, "R3");
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (q_main.size() > 0) begin
        int ep, em, eo, es;
        string t;
        ep = q_pre.pop_front(); em = q_main.pop_front(); eo = q_post.pop_front();
        es = q_st.pop_front(); t = q_tag.pop_front();
        checks++;
        if (int'(pre_tap) != ep || int'(main_tap) != em || int'(post_tap) != eo || int'(stat_word) != es) begin
          bad++;
          $display("FAIL %s: pre=%0d main=%0d post=%0d stat=%h expected pre=%0d main=%0d post=%0d stat=%h",
                   t, pre_tap, main_tap, post_tap, stat_word, ep, em, eo, es[15:0]);
        end
      end
    end
  end

  initial begin : watchdog
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (int'(main_tap) != MAIN_INIT || int'(pre_tap) != PRE_INIT || int'(post_tap) != POST_INIT || stat_word[5:0] != 0) begin
      bad++;
      $display("FAIL R1: in reset main=%0d stat=%h expected main=%0d stat=0", main_tap, stat_word, MAIN_INIT);
    end
    rst_n = 1;
    step(16'h0000, "R1");
    step(16'h0004, "R2 main inc");
    step(16'h0004, "R3 held request");
    step(16'h0004, "R3 held request");
    step(16'h0000, "R3 hold clears");
    step(16'h000C, "R5 reserved code");
    pulse(16'h0002, "R2 pre dec");
    @(negedge clk); main_max_ovr = 5'd22; main_max_ovr_en = 1;
    pulse(16'h0004, "R8 main inc under override");
    pulse(16'h0004, "R4 R8 main at override max");
    @(negedge clk); main_min_ovr = 5'd6; main_min_ovr_en = 1;
    for (int i = 0; i < 17; i++) pulse(16'h0008, "R4 R8 main down to override min");
    for (int i = 0; i < 4; i++) pulse(16'h0002, "R4 pre down to zero");
    step(16'h1006, "R6 init beats requests");
    step(16'h0000, "R3");
    for (int i = 0; i < 33; i++) pulse(16'h0010, "R4 post up to default max");
    @(negedge clk); main_max_ovr_en = 0;
    pulse(16'h1000, "R6 init");
    for (int i = 0; i < 12; i++) pulse(16'h0004, "R8 main default max");
    step(16'h3000, "R7 preset wins over init");
    step(16'h0000, "R3");
    @(negedge clk); rx_ready = 1;
    step(16'h0015, "R10 R9 all three inc");
    step(16'h0000, "R9 ready high");
    @(negedge clk); rx_ready = 0;
    step(16'h0021, "R10 post dec pre inc");
    step(16'h0000, "R9 ready low");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule